// File: doc/BRIEF.md
# Core Clock and Power Mode Controller

This block sits between a simple register access port and the chip's power sequencer and clock generator. Software selects one of two registers. The power mode register takes a two-bit code. Writing the IDLE or SLEEP code sends a single-cycle request to the power sequencer. The mode register always reads back zero, because software can only issue a read while the core is running.

The clock configuration register holds a four-bit ratio: the multiplier applied to the reference clock to produce the core clock. A write to it does not take effect at once. The controller first waits until the outstanding memory request count, which models the memory system, reaches zero. It then sends a one-cycle change request with the new ratio to the PLL interface. It waits for the PLL to report loss of lock and then relock, and only then commits the new ratio and acknowledges the write. The register port is stalled for the whole sequence. A read of the register returns the ratio currently in effect.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset, reg_ack, pll_change_req, pwr_idle_req and pwr_sleep_req are low, and a read of the clock configuration register (reg_sel=1) returns RESET_RATIO.
- R2: A write to the mode register (reg_sel=0) with wdata[1:0]=1 produces exactly one single-cycle pwr_idle_req pulse, in the same cycle as the write's reg_ack.
- R3: A mode register write with wdata[1:0]=3 produces exactly one single-cycle pwr_sleep_req pulse, in the same cycle as reg_ack.
- R4: A mode register write with wdata[1:0]=0 (ACTIVE) or 2 (reserved) is acknowledged and produces no pwr_idle_req or pwr_sleep_req pulse.
- R5: A read of the mode register returns zero in the mode field, reg_rdata[1:0].
- R6: Write data bits above each register's field are ignored: a clock configuration write stores only wdata[3:0], and a mode write decodes only wdata[1:0]. With the default RSVD_FILL=0, those upper bits read as zero.
- R7: After a clock configuration write, pll_change_req is not raised until mem_outstanding has been sampled at zero.
- R8: pll_change_req is a single-cycle pulse, issued once per clock configuration write, and pll_ratio carries the newly written ratio during that pulse.
- R9: A clock configuration write is acknowledged only after pll_locked has dropped and risen again following the change request. The effective ratio changes only in the cycle of that acknowledge.
- R10: A read of the clock configuration register returns the ratio in effect: the old value before a change completes and the new value after it.
- R11: reg_ack is high for one cycle per access. Reads and mode writes are acknowledged one clock after the request is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Access request, held high until reg_ack |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 1 | 0 = power mode register, 1 = clock configuration register |
| reg_wdata | input | DATA_W | Write data |
| reg_ack | output | 1 | One-cycle access completion |
| reg_rdata | output | DATA_W | Read data, valid with reg_ack on reads |
| mem_outstanding | input | CNT_W | Count of memory requests still in flight |
| pll_change_req | output | 1 | One-cycle request for a ratio change |
| pll_ratio | output | RATIO_W | Requested ratio, valid with pll_change_req |
| pll_locked | input | 1 | PLL lock indicator |
| pwr_idle_req | output | 1 | One-cycle request to enter IDLE |
| pwr_sleep_req | output | 1 | One-cycle request to enter SLEEP |

## Verification
Some properties are checked on every cycle. The acknowledge is a one-cycle pulse. The power pulses are never both high and always coincide with an acknowledge. pll_change_req only follows a cycle in which mem_outstanding was zero and never coincides with an acknowledge. The effective ratio changes only on an acknowledge. A mode read shows a zero field. Other behaviour only the directed scenarios can show: the exact stall length during a held-off drain, that the acknowledge waits for a real lock drop and relock, that the reserved code produces no pulse, and that readback moves from the old ratio to the new one.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE      = 2'd0,
      SEQ_DRAIN     = 2'd1,
      SEQ_PLL_REQ   = 2'd2,
      SEQ_WAIT_LOCK = 2'd3
   } seq_state_e;

   localparam logic       SEL_MODE   = 1'b0;
   localparam logic       SEL_CFG    = 1'b1;
   localparam int         MODE_W     = 2;
   localparam logic [1:0] MODE_ACT   = 2'd0;
   localparam logic [1:0] MODE_IDLE  = 2'd1;
   localparam logic [1:0] MODE_RSVD  = 2'd2;
   localparam logic [1:0] MODE_SLEEP = 2'd3;
endpackage

// File: rtl/clkpm_mode_ctl.sv
module clkpm_mode_ctl
   import clkpm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_code,
   output logic              idle_req,
   output logic              sleep_req
);
   logic go_idle, go_sleep;

   // The ACTIVE and reserved codes fall through with no request.
   always_comb begin
      go_idle  = 1'b0;
      go_sleep = 1'b0;
      if (mode_wr) begin
         unique case (mode_code)
            MODE_IDLE:  go_idle  = 1'b1;
            MODE_SLEEP: go_sleep = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_req  <= 1'b0;
         sleep_req <= 1'b0;
      end else begin
         idle_req  <= go_idle;
         sleep_req <= go_sleep;
      end
   end
endmodule

// File: rtl/clkpm_freq_seq.sv
module clkpm_freq_seq
   import clkpm_pkg::*;
#(
   parameter int                 RATIO_W     = 4,
   parameter int                 CNT_W       = 4,
   parameter logic [RATIO_W-1:0] RESET_RATIO = 4'd5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [RATIO_W-1:0] new_ratio,
   input  logic [CNT_W-1:0]   mem_outstanding,
   input  logic               pll_locked,
   output logic               busy,
   output logic               done,
   output logic               pll_change_req,
   output logic [RATIO_W-1:0] pll_ratio,
   output logic [RATIO_W-1:0] ratio_q
);
   seq_state_e         state_q, state_d;
   logic [RATIO_W-1:0] pend_q;
   logic               unlock_seen_q;
   logic               drained;

   assign drained        = (mem_outstanding == '0);
   assign busy           = (state_q != SEQ_IDLE);
   assign pll_change_req = (state_q == SEQ_PLL_REQ);
   assign pll_ratio      = pend_q;
   assign done           = (state_q == SEQ_WAIT_LOCK) && unlock_seen_q && pll_locked;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:      if (start)   state_d = SEQ_DRAIN;
         SEQ_DRAIN:     if (drained) state_d = SEQ_PLL_REQ;
         SEQ_PLL_REQ:                state_d = SEQ_WAIT_LOCK;
         SEQ_WAIT_LOCK: if (done)    state_d = SEQ_IDLE;
         default:                    state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= SEQ_IDLE;
         pend_q        <= RESET_RATIO;
         ratio_q       <= RESET_RATIO;
         unlock_seen_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start && !busy) pend_q <= new_ratio;
         if (state_q == SEQ_PLL_REQ) unlock_seen_q <= 1'b0;
         else if (state_q == SEQ_WAIT_LOCK && !pll_locked) unlock_seen_q <= 1'b1;
         if (done) ratio_q <= pend_q;
      end
   end
endmodule

// File: rtl/clkpm_reg_port.sv
module clkpm_reg_port
   import clkpm_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int RATIO_W   = 4,
   parameter bit RSVD_FILL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_req,
   input  logic               reg_we,
   input  logic               reg_sel,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               seq_busy,
   input  logic               seq_done,
   input  logic [RATIO_W-1:0] ratio_q,
   output logic               reg_ack,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               mode_wr,
   output logic [MODE_W-1:0]  mode_code,
   output logic               cfg_start,
   output logic [RATIO_W-1:0] cfg_ratio
);
   logic              accept, rd_acc;
   logic [DATA_W-1:0] fill_w, rd_word;

   generate
      if (RSVD_FILL) begin : g_fill_ones
         assign fill_w = '1;
      end else begin : g_fill_zero
         assign fill_w = '0;
      end
   endgenerate

   assign accept    = reg_req && !reg_ack && !seq_busy;
   assign rd_acc    = accept && !reg_we;
   assign mode_wr   = accept && reg_we && (reg_sel == SEL_MODE);
   assign cfg_start = accept && reg_we && (reg_sel == SEL_CFG);
   assign mode_code = reg_wdata[MODE_W-1:0];
   assign cfg_ratio = reg_wdata[RATIO_W-1:0];

   always_comb begin
      if (reg_sel == SEL_CFG) rd_word = {fill_w[DATA_W-1:RATIO_W], ratio_q};
      else                    rd_word = {fill_w[DATA_W-1:MODE_W], {MODE_W{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_ack   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_ack <= (accept && !cfg_start) || seq_done;
         if (rd_acc) reg_rdata <= rd_word;
      end
   end
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
   import clkpm_pkg::*;
#(
   parameter int                 DATA_W      = 32,
   parameter int                 RATIO_W     = 4,
   parameter int                 CNT_W       = 4,
   parameter logic [RATIO_W-1:0] RESET_RATIO = 4'd5,
   parameter bit                 RSVD_FILL   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_req,
   input  logic               reg_we,
   input  logic               reg_sel,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic               reg_ack,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [CNT_W-1:0]   mem_outstanding,
   output logic               pll_change_req,
   output logic [RATIO_W-1:0] pll_ratio,
   input  logic               pll_locked,
   output logic               pwr_idle_req,
   output logic               pwr_sleep_req
);
   generate
      if (RATIO_W < 1 || RATIO_W >= DATA_W) begin : g_bad_ratio_w
         $error("clk_pwr_ctrl: RATIO_W must lie in 1..DATA_W-1");
      end
      if (DATA_W <= MODE_W) begin : g_bad_data_w
         $error("clk_pwr_ctrl: DATA_W must exceed the mode field width");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("clk_pwr_ctrl: CNT_W must be at least 1");
      end
   endgenerate

   logic               seq_busy, seq_done, mode_wr, cfg_start;
   logic [MODE_W-1:0]  mode_code;
   logic [RATIO_W-1:0] cfg_ratio, ratio_q;

   clkpm_reg_port #(.DATA_W(DATA_W), .RATIO_W(RATIO_W), .RSVD_FILL(RSVD_FILL)) port_i (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .seq_busy(seq_busy), .seq_done(seq_done), .ratio_q(ratio_q),
      .reg_ack(reg_ack), .reg_rdata(reg_rdata), .mode_wr(mode_wr), .mode_code(mode_code),
      .cfg_start(cfg_start), .cfg_ratio(cfg_ratio)
   );

   clkpm_mode_ctl mode_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
      .idle_req(pwr_idle_req), .sleep_req(pwr_sleep_req)
   );

   clkpm_freq_seq #(.RATIO_W(RATIO_W), .CNT_W(CNT_W), .RESET_RATIO(RESET_RATIO)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(cfg_start), .new_ratio(cfg_ratio),
      .mem_outstanding(mem_outstanding), .pll_locked(pll_locked), .busy(seq_busy),
      .done(seq_done), .pll_change_req(pll_change_req), .pll_ratio(pll_ratio),
      .ratio_q(ratio_q)
   );
endmodule

// File: rtl/clk_pwr_ctrl_chk.sv
module clk_pwr_ctrl_chk #(
   parameter int DATA_W  = 32,
   parameter int RATIO_W = 4,
   parameter int CNT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_req,
   input logic               reg_we,
   input logic               reg_sel,
   input logic               reg_ack,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic [CNT_W-1:0]   mem_outstanding,
   input logic               pll_change_req,
   input logic               pwr_idle_req,
   input logic               pwr_sleep_req,
   input logic [RATIO_W-1:0] ratio_q
);
   a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ack |=> !reg_ack);
   a_r2_idle_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_idle_req |-> reg_ack);
   a_r3_sleep_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_sleep_req |-> reg_ack);
   a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_idle_req && pwr_sleep_req));
   a_r5_mode_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_ack && reg_req && !reg_we && !reg_sel) |-> (reg_rdata[1:0] == 2'b00));
   a_r7_drained_first: assert property (@(posedge clk) disable iff (!rst_n)
      pll_change_req |-> ($past(mem_outstanding) == '0));
   a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      pll_change_req |=> !pll_change_req);
   a_r9_no_ack_at_req: assert property (@(posedge clk) disable iff (!rst_n)
      pll_change_req |-> !reg_ack);
   a_r9_ratio_moves_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_q) |-> reg_ack);
endmodule

bind clk_pwr_ctrl clk_pwr_ctrl_chk #(.DATA_W(DATA_W), .RATIO_W(RATIO_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/clk_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_pwr_ctrl_tb_top;
   localparam int DATA_W   = 32;
   localparam int RATIO_W  = 4;
   localparam int CNT_W    = 4;
   localparam int LOCK_DLY = 5;
   localparam logic [RATIO_W-1:0] RST_RATIO = 4'd5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_req = 1'b0, reg_we = 1'b0, reg_sel = 1'b0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic              reg_ack;
   logic [DATA_W-1:0] reg_rdata;
   logic [CNT_W-1:0]  mem_out = '0;
   logic              pll_change_req;
   logic [RATIO_W-1:0] pll_ratio;
   logic              pll_locked = 1'b1;
   logic              pwr_idle_req, pwr_sleep_req;

   int checks = 0, failures = 0;
   int idle_cnt = 0, sleep_cnt = 0, preq_cnt = 0, preq_bad_mem = 0;
   logic [RATIO_W-1:0] preq_ratio = '0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   clk_pwr_ctrl #(.DATA_W(DATA_W), .RATIO_W(RATIO_W), .CNT_W(CNT_W), .RESET_RATIO(RST_RATIO)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
      .mem_outstanding(mem_out), .pll_change_req(pll_change_req), .pll_ratio(pll_ratio),
      .pll_locked(pll_locked), .pwr_idle_req(pwr_idle_req), .pwr_sleep_req(pwr_sleep_req)
   );

   // Pulse monitor: samples on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (pwr_idle_req)  idle_cnt++;
            if (pwr_sleep_req) sleep_cnt++;
            if (pwr_idle_req && !reg_ack) begin
               checks++; failures++;
               $display("FAIL R2 idle pulse without ack: ack=%0d expected 1", reg_ack);
            end
            if (pwr_sleep_req && !reg_ack) begin
               checks++; failures++;
               $display("FAIL R3 sleep pulse without ack: ack=%0d expected 1", reg_ack);
            end
         end
      end
   end

   // PLL model: drop lock after a change request, relock LOCK_DLY cycles later
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && pll_change_req) begin
            preq_cnt++;
            preq_ratio = pll_ratio;
            if (mem_out != '0) preq_bad_mem++;
            pll_locked = 1'b0;
            repeat (LOCK_DLY) @(negedge clk);
            pll_locked = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic access(input logic sel, input logic we, input logic [DATA_W-1:0] wd,
                         output logic [DATA_W-1:0] rd, output int lat);
      @(negedge clk);
      reg_req = 1'b1; reg_sel = sel; reg_we = we; reg_wdata = wd;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!reg_ack && lat < 2000);
      rd = reg_rdata;
      reg_req = 1'b0; reg_we = 1'b0; reg_wdata = '0;
      if (lat >= 2000) chk(1'b0, "R11", "access timeout", lat, 1);
   endtask

   task automatic t_reset;
      logic [DATA_W-1:0] rd; int lat;
      chk(reg_ack == 1'b0, "R1", "ack after reset", reg_ack, 0);
      chk(pll_change_req == 1'b0, "R1", "pll req after reset", pll_change_req, 0);
      chk(!pwr_idle_req && !pwr_sleep_req, "R1", "power pulses after reset",
          {pwr_idle_req, pwr_sleep_req}, 0);
      access(1'b1, 1'b0, '0, rd, lat);
      chk(rd == DATA_W'(RST_RATIO), "R1", "ratio after reset", rd, RST_RATIO);
      chk(lat == 1, "R11", "read latency", lat, 1);
      @(negedge clk);
      chk(reg_ack == 1'b0, "R11", "ack single cycle", reg_ack, 0);
   endtask

   task automatic t_mode_writes;
      logic [DATA_W-1:0] rd; int lat; int i0, s0;
      i0 = idle_cnt; s0 = sleep_cnt;
      access(1'b0, 1'b1, 32'd1, rd, lat);
      repeat (2) @(negedge clk);
      chk(idle_cnt == i0 + 1, "R2", "idle pulses", idle_cnt - i0, 1);
      chk(sleep_cnt == s0, "R2", "sleep pulses on idle write", sleep_cnt - s0, 0);
      chk(lat == 1, "R11", "mode write latency", lat, 1);
      i0 = idle_cnt; s0 = sleep_cnt;
      access(1'b0, 1'b1, 32'd3, rd, lat);
      repeat (2) @(negedge clk);
      chk(sleep_cnt == s0 + 1, "R3", "sleep pulses", sleep_cnt - s0, 1);
      chk(idle_cnt == i0, "R3", "idle pulses on sleep write", idle_cnt - i0, 0);
      i0 = idle_cnt; s0 = sleep_cnt;
      access(1'b0, 1'b1, 32'd2, rd, lat);
      access(1'b0, 1'b1, 32'd0, rd, lat);
      repeat (2) @(negedge clk);
      chk(idle_cnt == i0 && sleep_cnt == s0, "R4", "pulses for codes 2 and 0",
          (idle_cnt - i0) + (sleep_cnt - s0), 0);
      // upper bits set, field = 0: must stay ACTIVE (R6)
      i0 = idle_cnt; s0 = sleep_cnt;
      access(1'b0, 1'b1, 32'hFFFF_FFFC, rd, lat);
      repeat (2) @(negedge clk);
      chk(idle_cnt == i0 && sleep_cnt == s0, "R6", "pulses for mode write with upper bits",
          (idle_cnt - i0) + (sleep_cnt - s0), 0);
   endtask

   task automatic t_mode_read;
      logic [DATA_W-1:0] rd; int lat;
      access(1'b0, 1'b1, 32'd1, rd, lat);
      access(1'b0, 1'b0, '0, rd, lat);
      chk(rd[1:0] == 2'b00, "R5", "mode field read", rd[1:0], 0);
      chk(rd == '0, "R6", "mode read reserved bits", rd, 0);
   endtask

   task automatic t_cfg_drain;
      logic [DATA_W-1:0] rd; int lat; int p0;
      p0 = preq_cnt;
      mem_out = 4'd3;
      fork
         access(1'b1, 1'b1, 32'd9, rd, lat);
         begin
            repeat (8) @(negedge clk);
            chk(preq_cnt == p0, "R7", "pll requests while draining", preq_cnt - p0, 0);
            mem_out = '0;
         end
      join
      chk(preq_bad_mem == 0, "R7", "pll request with memory busy", preq_bad_mem, 0);
      chk(preq_cnt == p0 + 1, "R8", "pll request count", preq_cnt - p0, 1);
      chk(preq_ratio == 4'd9, "R8", "pll ratio", preq_ratio, 9);
      chk(lat >= 8 + LOCK_DLY + 1, "R9", "write latency covers drain and relock", lat,
          8 + LOCK_DLY + 1);
      access(1'b1, 1'b0, '0, rd, lat);
      chk(rd == 32'd9, "R10", "ratio after change", rd, 9);
   endtask

   task automatic t_cfg_reserved;
      logic [DATA_W-1:0] rd; int lat; int p0;
      p0 = preq_cnt;
      access(1'b1, 1'b0, '0, rd, lat);
      chk(rd == 32'd9, "R10", "old ratio before change", rd, 9);
      access(1'b1, 1'b1, 32'hABCD_EF72, rd, lat);
      chk(preq_cnt == p0 + 1, "R8", "one request per write", preq_cnt - p0, 1);
      chk(lat >= LOCK_DLY + 2, "R9", "ack waits for relock", lat, LOCK_DLY + 2);
      access(1'b1, 1'b0, '0, rd, lat);
      chk(rd == 32'd2, "R6", "only low field stored", rd, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_writes();
      t_mode_read();
      t_cfg_drain();
      t_cfg_reserved();
      repeat (3) @(negedge clk);
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         checks++; failures++;
         $display("FAIL watchdog: actual=expired expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule